// File: doc/BRIEF.md
# Lines-per-Field Counter and Serializer

This block measures how many horizontal lines arrive in each video field and reports the figure on a single wire. It watches two active-low sync inputs sampled on a system clock. Every horizontal sync leading edge (falling `hsync_ni`) that arrives while vertical sync is inactive advances a saturating counter. Each vertical sync leading edge (falling `vsync_ni`) latches the counter and restarts it. Lines that fall inside the vertical sync pulse are not counted, so the figure comes out a few lines below the true field length.

The latched count is also sent serially on `vf_o`, most significant bit first. Each bit takes one line, and the horizontal sync leading edges act as the bit clock. The first bit appears on the `START_EDGE`-th horizontal sync leading edge after the vertical sync leading edge. Because the value sent is frozen at the vertical edge, it cannot change during a burst. Outside the burst `vf_o` is low. A receiver decodes the stream using horizontal sync as its clock and vertical sync as its frame marker. The latched value is also available in parallel on `field_count_o`.

Top module: `field_line_serializer`

## Requirements
- R1: After reset, `vf_o` is 0 and `field_count_o` is 0.
- R2: The counter advances by one for each falling edge of `hsync_ni` seen while `vsync_ni` is high. Falling edges of `hsync_ni` seen while `vsync_ni` is low do not advance it.
- R3: On each falling edge of `vsync_ni`, the current count is copied to `field_count_o` and the counter restarts from zero. At all other times `field_count_o` holds its value.
- R4: The counter saturates at 2^CNT_W-1 (2047 by default) and does not wrap.
- R5: After a falling edge of `vsync_ni`, the value latched at that edge is driven on `vf_o`, most significant bit first, one bit per falling edge of `hsync_ni`. The first bit appears on the START_EDGE-th edge (3 by default) and the last on edge START_EDGE+CNT_W-1. Each bit holds until the next falling edge of `hsync_ni`.
- R6: `vf_o` is 0 from the falling edge of `vsync_ni` until the first bit of the burst. It is also 0 from the edge after the last bit until the next falling edge of `vsync_ni`.
- R7: `vf_o` changes only after a falling edge of `hsync_ni` or `vsync_ni`. It is steady between those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Horizontal sync, active low, asynchronous to clk_i |
| vsync_ni | input | 1 | Vertical sync, active low, asynchronous to clk_i |
| vf_o | output | 1 | Serial line count, one bit per line, MSB first |
| field_count_o | output | CNT_W | Count latched at the last vertical sync leading edge |

## Verification
The checker assumes that each sync pulse lasts longer than the synchronizer and edge detector. It also assumes that a horizontal and a vertical leading edge never reach the edge detectors in the same clock cycle; if they did, the horizontal edge would be dropped in favour of the restart. The bench keeps to these limits. It holds horizontal sync low for two clocks of a sixteen-clock line and changes vertical sync only in mid-line, eight clocks away from any horizontal edge. Every field is at least START_EDGE+CNT_W lines long, so each burst finishes before the next vertical edge.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  localparam int unsigned CNT_W_DEF  = 11;
  localparam int unsigned START_DEF  = 3;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/lpf_sync_edge.sv
module lpf_sync_edge #(
  parameter int unsigned STAGES = lpf_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_ni,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= d_ni;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/lpf_line_counter.sv
module lpf_line_counter #(
  parameter int unsigned CNT_W = lpf_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_fall_i,
  input  logic             vs_lvl_i,
  input  logic             vs_fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] field_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      field_q <= '0;
    end else if (vs_fall_i) begin
      field_q <= cnt_q;
      cnt_q   <= '0;
    end else if (hs_fall_i && vs_lvl_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign field_o = field_q;
endmodule

// File: rtl/lpf_serializer.sv
module lpf_serializer #(
  parameter int unsigned CNT_W = lpf_pkg::CNT_W_DEF,
  parameter int unsigned START = lpf_pkg::START_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_fall_i,
  input  logic             vs_fall_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             vf_o
);
  localparam int unsigned LAST  = START + CNT_W - 1;
  localparam int unsigned IDX_W = $clog2(LAST + 3);
  localparam logic [IDX_W-1:0] IDX_STOP  = IDX_W'(LAST + 1);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(START);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(LAST);

  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [CNT_W-1:0] sreg_q;
  logic             vf_q;

  assign idx_nxt = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      sreg_q <= '0;
      vf_q   <= 1'b0;
    end else if (vs_fall_i) begin
      idx_q  <= '0;
      sreg_q <= load_i;
      vf_q   <= 1'b0;
    end else if (hs_fall_i) begin
      if (idx_q != IDX_STOP) idx_q <= idx_nxt;
      // in-window edge emits MSB; saturated index yields idle low
      if (idx_q != IDX_STOP && idx_nxt >= IDX_FIRST && idx_nxt <= IDX_LAST) begin
        vf_q   <= sreg_q[CNT_W-1];
        sreg_q <= sreg_q << 1;
      end else begin
        vf_q <= 1'b0;
      end
    end
  end

  assign vf_o = vf_q;
endmodule

// File: rtl/field_line_serializer.sv
module field_line_serializer #(
  parameter int unsigned CNT_W  = lpf_pkg::CNT_W_DEF,
  parameter int unsigned START  = lpf_pkg::START_DEF,
  parameter int unsigned STAGES = lpf_pkg::SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_ni,
  input  logic             vsync_ni,
  output logic             vf_o,
  output logic [CNT_W-1:0] field_count_o
);
  logic hs_lvl, hs_fall, vs_lvl, vs_fall;
  logic [CNT_W-1:0] line_cnt;

  lpf_sync_edge #(.STAGES(STAGES)) u_hs (
    .clk_i, .rst_ni, .d_ni(hsync_ni), .lvl_o(hs_lvl), .fall_o(hs_fall)
  );

  lpf_sync_edge #(.STAGES(STAGES)) u_vs (
    .clk_i, .rst_ni, .d_ni(vsync_ni), .lvl_o(vs_lvl), .fall_o(vs_fall)
  );

  lpf_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .hs_fall_i(hs_fall), .vs_lvl_i(vs_lvl), .vs_fall_i(vs_fall),
    .cnt_o(line_cnt), .field_o(field_count_o)
  );

  lpf_serializer #(.CNT_W(CNT_W), .START(START)) u_ser (
    .clk_i, .rst_ni,
    .hs_fall_i(hs_fall), .vs_fall_i(vs_fall),
    .load_i(line_cnt), .vf_o(vf_o)
  );

  logic unused_hs_lvl;
  assign unused_hs_lvl = hs_lvl;
endmodule

// File: rtl/lpf_checker.sv
module lpf_checker #(
  parameter int unsigned CNT_W = lpf_pkg::CNT_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hs_fall_i,
  input logic             vs_fall_i,
  input logic             vs_lvl_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] field_i,
  input logic             vf_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_fall_i |=> cnt_i >= $past(cnt_i));

  a_r2_hold_in_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vs_lvl_i && !vs_fall_i) |=> $stable(cnt_i));

  a_r3_field_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_fall_i |=> $stable(field_i));

  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall_i |=> cnt_i == '0);

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX && !vs_fall_i) |=> cnt_i == CNT_MAX);

  a_r6_low_after_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall_i |=> !vf_i);

  a_r7_vf_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_fall_i && !vs_fall_i) |=> $stable(vf_i));
endmodule

bind field_line_serializer lpf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni,
  .hs_fall_i(hs_fall), .vs_fall_i(vs_fall), .vs_lvl_i(vs_lvl),
  .cnt_i(line_cnt), .field_i(field_count_o), .vf_i(vf_o)
);

// File: tb/sim_field_line_serializer.sv
module sim_field_line_serializer;
  localparam int W   = 6;
  localparam int ST  = 3;
  localparam int MAXC = (1 << W) - 1;
  localparam int LP  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_n = 1'b1;
  logic vs_n = 1'b1;
  logic vf;
  logic [W-1:0] fc;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  field_line_serializer #(.CNT_W(W), .START(ST), .STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsync_ni(hs_n), .vsync_ni(vs_n),
    .vf_o(vf), .field_count_o(fc)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one line: hsync low for two clocks; vsync changes at mid-line
  task automatic run_line(input int i, input int rise_at, input int fall_at,
                          input int exp_vf);
    int s6 = 0;
    for (int k = 0; k < LP; k++) begin
      @(negedge clk);
      hs_n = (k < 2) ? 1'b0 : 1'b1;
      if (k == 8 && i == rise_at) vs_n = 1'b1;
      if (k == 8 && i == fall_at) vs_n = 1'b0;
      if (k == 6) s6 = int'(vf);
      if (k == 12) begin
        if (exp_vf >= 0) chk((i >= ST && i < ST + W) ? "R5 burst bit" : "R6 idle low",
                             int'(vf), exp_vf);
        chk("R7 steady within line", int'(vf), s6);
      end
    end
  endtask

  task automatic run_field(input int t, inout int prev);
    int exp_cnt;
    for (int i = 1; i <= t; i++) begin
      int e;
      e = (i >= ST && i < ST + W) ? ((prev >> (W - 1 - (i - ST))) & 1) : 0;
      run_line(i, ST, t, e);
    end
    exp_cnt = (t - 3 > MAXC) ? MAXC : t - 3;
    chk((t - 3 > MAXC) ? "R4 saturated count" : "R2 R3 field count", int'(fc), exp_cnt);
    prev = exp_cnt;
  endtask

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    chk("R1 vf after reset", int'(vf), 0);
    chk("R1 count after reset", int'(fc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // prime: one counted edge, then vsync falls in mid-line
    run_line(1, -1, 1, -1);
    repeat (4) @(negedge clk);
    chk("R2 single edge count", int'(fc), 1);
    prev = 1;
    for (int t = ST + W; t <= 72; t++) run_field(t, prev);
    for (int r = 0; r < 3; r++) begin
      run_field(70, prev);
      run_field(ST + W + r, prev);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule